// File: doc/BRIEF.md
# Card Power and Signal-Voltage Sequencer

This block is the control state machine for a removable-card interface. It moves the card signal pins (data, command and clock) between three drive states: driven low, driven high with the card not enabled, and fully powered. It also runs the handshake that switches the signalling level from 3.3 V down to 1.8 V. A power-down first pulses the interface controller's reset and then leaves the pins driven low, so the card cannot draw supply current through its signal lines. A power-up always goes through the driven-high state and waits there before the pins are enabled.

The voltage switch works in two steps. A start request sets the switch-enable bit and clears the completion flag. A go request, accepted only while switch-enable is set, raises the switch bit. The block then waits for the pad logic to report completion, or gives up after a timeout. In both cases it clears the completion flag, the clock-stopped flag, switch-enable and the switch bit. A timeout also leaves a sticky error flag. Every wait is counted in pulses of a time-base input, and the length of each wait is a parameter.

Top module: `card_pwr_seq`

## Requirements
- R1: After reset, pin_drive is 2'b00 (all lines low), and ctrl_rst, sw_en, sw_act, done_flag, ckstop_flag and err_flag are all 0.
- R2: A power-off request accepted in idle clears sw_en and sw_act and raises ctrl_rst for RST_TICKS time-base pulses. pin_drive does not change during the pulse. When the pulse ends, pin_drive becomes 2'b00.
- R3: A power-on request accepted in idle sets pin_drive to 2'b01 (lines high, not enabled) for ON_TICKS time-base pulses, then sets it to 2'b10 (powered). pin_drive never moves from 2'b00 directly to 2'b10.
- R4: sw_en and sw_act keep their values through a power-on sequence.
- R5: A switch-start request accepted in idle sets sw_en and clears done_flag on the same clock edge.
- R6: A go request in idle while sw_en is 1 sets sw_act. A go request while sw_en is 0 is ignored, and sw_act stays 0.
- R7: While sw_act is 1, a vsw_done pulse ends the wait. On the edge that follows the flag being set, sw_en, sw_act, done_flag and ckstop_flag all return to 0, and err_flag stays 0.
- R8: If no completion arrives within TIMEOUT_TICKS time-base pulses of sw_act rising, the block clears sw_en, sw_act, done_flag and ckstop_flag and sets err_flag.
- R9: err_flag stays set until an err_clr pulse clears it.
- R10: Requests that arrive while a wait is running (reset pulse, power-on wait or switch wait) are ignored. For example, a power-off request during the switch wait neither raises ctrl_rst nor changes pin_drive.
- R11: When several requests arrive in idle on the same cycle, the order of priority is power-off, then power-on, then switch-start, then go.
- R12: done_flag is set by a vsw_done pulse and ckstop_flag by a clk_stop pulse. Both hold their value after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base pulse, one cycle wide; all waits count these pulses |
| pwr_off_req | input | 1 | Request a power-down sequence |
| pwr_on_req | input | 1 | Request a power-up sequence |
| vsw_start_req | input | 1 | Arm the voltage switch (sets switch-enable) |
| vsw_go_req | input | 1 | Request the 1.8 V switch |
| vsw_done | input | 1 | Switch-complete pulse from the pad logic |
| clk_stop | input | 1 | Clock-stopped pulse from the pad logic |
| err_clr | input | 1 | Clears the sticky timeout flag |
| ctrl_rst | output | 1 | Controller reset pulse |
| pin_drive | output | 2 | Pin state: 00 lines low, 01 lines high, 10 powered |
| sw_en | output | 1 | Voltage-switch enable bit |
| sw_act | output | 1 | Voltage-switch bit |
| done_flag | output | 1 | Sticky switch-complete flag |
| ckstop_flag | output | 1 | Sticky clock-stopped flag |
| err_flag | output | 1 | Sticky switch-timeout flag |

## Verification
The assertions assume that vsw_done and clk_stop arrive as single-cycle pulses and not as held levels. A held vsw_done would set done_flag again straight after the clear at the end of a switch. They also assume that rst is held for several cycles at start-up, so every $past term sees register values and not unknowns. The bench meets both assumptions: it drives every request and status input as a one-cycle pulse on the falling edge, and it asserts reset for five cycles. It uses short wait parameters and a tick every fourth cycle. Each wait length is then checked against a window one tick wide, because the phase of the tick relative to the request is free.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RSTP = 2'd1,
    ST_ONW  = 2'd2,
    ST_VSW  = 2'd3
  } cps_state_e;

  localparam logic [1:0] PD_LOW  = 2'b00;
  localparam logic [1:0] PD_HIGH = 2'b01;
  localparam logic [1:0] PD_PWR  = 2'b10;

  localparam int FL_DONE = 0;
  localparam int FL_CKST = 1;
  localparam int FL_ERR  = 2;
  localparam int FL_NUM  = 3;
endpackage

// File: rtl/cps_timer.sv
module cps_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick && (cnt != limit)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == limit);
endmodule

// File: rtl/cps_flags.sv
module cps_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr[i]) q[i] <= 1'b0;
      else if (set[i])   q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
  import cps_pkg::*;
#(
  parameter int CW            = 8,
  parameter int RST_TICKS     = 2,
  parameter int ON_TICKS      = 1000,
  parameter int TIMEOUT_TICKS = 10000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_off_req,
  input  logic          pwr_on_req,
  input  logic          vsw_start_req,
  input  logic          vsw_go_req,
  input  logic          done_seen,
  input  logic          tmr_exp,
  output logic          tmr_clr,
  output logic [CW-1:0] tmr_limit,
  output logic          ctrl_rst,
  output logic [1:0]    pin_drive,
  output logic          sw_en,
  output logic          sw_act,
  output logic          clr_done,
  output logic          clr_ckst,
  output logic          set_err
);
  cps_state_e st;
  logic       start_ok;
  logic       vsw_end;

  assign start_ok = (st == ST_IDLE) && vsw_start_req && !pwr_off_req && !pwr_on_req;
  assign vsw_end  = (st == ST_VSW) && (done_seen || tmr_exp);
  assign clr_done = start_ok || vsw_end;
  assign clr_ckst = vsw_end;
  assign set_err  = (st == ST_VSW) && tmr_exp && !done_seen;
  assign tmr_clr  = (st == ST_IDLE);

  always_comb begin
    case (st)
      ST_RSTP: tmr_limit = CW'(RST_TICKS);
      ST_ONW:  tmr_limit = CW'(ON_TICKS);
      default: tmr_limit = CW'(TIMEOUT_TICKS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ctrl_rst  <= 1'b0;
      pin_drive <= PD_LOW;
      sw_en     <= 1'b0;
      sw_act    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (pwr_off_req) begin
            st       <= ST_RSTP;
            ctrl_rst <= 1'b1;
            sw_en    <= 1'b0;
            sw_act   <= 1'b0;
          end else if (pwr_on_req) begin
            st        <= ST_ONW;
            pin_drive <= PD_HIGH;
          end else if (vsw_start_req) begin
            sw_en <= 1'b1;
          end else if (vsw_go_req && sw_en) begin
            st     <= ST_VSW;
            sw_act <= 1'b1;
          end
        end
        ST_RSTP: begin
          if (tmr_exp) begin
            st        <= ST_IDLE;
            ctrl_rst  <= 1'b0;
            pin_drive <= PD_LOW;
          end
        end
        ST_ONW: begin
          if (tmr_exp) begin
            st        <= ST_IDLE;
            pin_drive <= PD_PWR;
          end
        end
        ST_VSW: begin
          if (vsw_end) begin
            st     <= ST_IDLE;
            sw_en  <= 1'b0;
            sw_act <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
  import cps_pkg::*;
#(
  parameter int RST_TICKS     = 2,
  parameter int ON_TICKS      = 1000,
  parameter int TIMEOUT_TICKS = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       pwr_off_req,
  input  logic       pwr_on_req,
  input  logic       vsw_start_req,
  input  logic       vsw_go_req,
  input  logic       vsw_done,
  input  logic       clk_stop,
  input  logic       err_clr,
  output logic       ctrl_rst,
  output logic [1:0] pin_drive,
  output logic       sw_en,
  output logic       sw_act,
  output logic       done_flag,
  output logic       ckstop_flag,
  output logic       err_flag
);
  localparam int MAX_A = (RST_TICKS > ON_TICKS) ? RST_TICKS : ON_TICKS;
  localparam int MAX_T = (MAX_A > TIMEOUT_TICKS) ? MAX_A : TIMEOUT_TICKS;
  localparam int CW    = $clog2(MAX_T + 1);

  logic          tmr_clr, tmr_exp;
  logic [CW-1:0] tmr_limit;
  logic          clr_done, clr_ckst, set_err;
  logic [FL_NUM-1:0] fl_set, fl_clr, fl_q;

  cps_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick),
    .limit(tmr_limit), .expired(tmr_exp)
  );

  cps_fsm #(
    .CW(CW), .RST_TICKS(RST_TICKS), .ON_TICKS(ON_TICKS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .pwr_off_req(pwr_off_req), .pwr_on_req(pwr_on_req),
    .vsw_start_req(vsw_start_req), .vsw_go_req(vsw_go_req),
    .done_seen(fl_q[FL_DONE]), .tmr_exp(tmr_exp),
    .tmr_clr(tmr_clr), .tmr_limit(tmr_limit),
    .ctrl_rst(ctrl_rst), .pin_drive(pin_drive),
    .sw_en(sw_en), .sw_act(sw_act),
    .clr_done(clr_done), .clr_ckst(clr_ckst), .set_err(set_err)
  );

  always_comb begin
    fl_set = '0;
    fl_clr = '0;
    fl_set[FL_DONE] = vsw_done;
    fl_set[FL_CKST] = clk_stop;
    fl_set[FL_ERR]  = set_err;
    fl_clr[FL_DONE] = clr_done;
    fl_clr[FL_CKST] = clr_ckst;
    fl_clr[FL_ERR]  = err_clr;
  end

  cps_flags #(.NF(FL_NUM)) u_flags (
    .clk(clk), .rst(rst), .set(fl_set), .clr(fl_clr), .q(fl_q)
  );

  assign done_flag   = fl_q[FL_DONE];
  assign ckstop_flag = fl_q[FL_CKST];
  assign err_flag    = fl_q[FL_ERR];
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_rst,
  input logic [1:0] pin_drive,
  input logic       sw_en,
  input logic       sw_act,
  input logic       done_flag,
  input logic       err_flag
);
  // R3: leaving lines-low must go to lines-high
  p_low_exit_high_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(pin_drive) == 2'b00 && pin_drive != 2'b00) |-> pin_drive == 2'b01);

  // R3: powered state is entered only from lines-high
  p_pwr_from_high_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(pin_drive) != 2'b10 && pin_drive == 2'b10) |-> $past(pin_drive) == 2'b01);

  // R2: switch bits are clear during the reset pulse
  p_rst_clears_sw_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_rst |-> (!sw_en && !sw_act));

  // R2: pins hold during the reset pulse
  p_pin_hold_in_rst_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rst && $past(ctrl_rst)) |-> $stable(pin_drive));

  // R6: switch bit only while enabled
  p_act_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    sw_act |-> sw_en);

  // R7: end of switch clears enable and completion
  p_end_clears_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_act) |-> (!sw_en && !done_flag));

  // R8: error appears only at the end of a switch
  p_err_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $fell(sw_act));
endmodule

bind card_pwr_seq cps_checker u_chk (
  .clk(clk), .rst(rst), .ctrl_rst(ctrl_rst), .pin_drive(pin_drive),
  .sw_en(sw_en), .sw_act(sw_act), .done_flag(done_flag), .err_flag(err_flag)
);

// File: tb/card_pwr_seq_tb.sv
module card_pwr_seq_tb;
  localparam int RT = 3;
  localparam int OT = 5;
  localparam int TT = 12;
  localparam int TP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic pwr_off_req = 1'b0, pwr_on_req = 1'b0;
  logic vsw_start_req = 1'b0, vsw_go_req = 1'b0;
  logic vsw_done = 1'b0, clk_stop = 1'b0, err_clr = 1'b0;
  logic ctrl_rst, sw_en, sw_act, done_flag, ckstop_flag, err_flag;
  logic [1:0] pin_drive;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  card_pwr_seq #(.RST_TICKS(RT), .ON_TICKS(OT), .TIMEOUT_TICKS(TT)) u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .pwr_off_req(pwr_off_req), .pwr_on_req(pwr_on_req),
    .vsw_start_req(vsw_start_req), .vsw_go_req(vsw_go_req),
    .vsw_done(vsw_done), .clk_stop(clk_stop), .err_clr(err_clr),
    .ctrl_rst(ctrl_rst), .pin_drive(pin_drive), .sw_en(sw_en),
    .sw_act(sw_act), .done_flag(done_flag), .ckstop_flag(ckstop_flag),
    .err_flag(err_flag)
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 0);
      c = (c + 1) % TP;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pin_drive == 2'b00, "R1 pin_drive", pin_drive, 0);
    chk({ctrl_rst, sw_en, sw_act} == 3'b000, "R1 controls", {ctrl_rst, sw_en, sw_act}, 0);
    chk({done_flag, ckstop_flag, err_flag} == 3'b000, "R1 flags",
        {done_flag, ckstop_flag, err_flag}, 0);
  endtask

  task automatic t_power_on();
    int n = 0;
    bit saw_low = 0;
    pwr_on_req = 1'b1; step(1); pwr_on_req = 1'b0;
    chk(pin_drive == 2'b01, "R3 lines high first", pin_drive, 1);
    while (pin_drive == 2'b01 && n < 500) begin
      step(1); n++;
      if (pin_drive == 2'b00) saw_low = 1;
    end
    chk(pin_drive == 2'b10, "R3 powered", pin_drive, 2);
    chk(!saw_low, "R3 no low", saw_low, 0);
    chk(n >= (OT - 1) * TP && n <= OT * TP + 2, "R3 wait length", n, OT * TP);
  endtask

  task automatic t_preserve();
    vsw_start_req = 1'b1; step(1); vsw_start_req = 1'b0;
    chk(sw_en == 1'b1, "R5 sw_en set", sw_en, 1);
    t_power_on();
    chk(sw_en == 1'b1, "R4 sw_en kept", sw_en, 1);
    chk(sw_act == 1'b0, "R4 sw_act kept", sw_act, 0);
  endtask

  task automatic t_power_off();
    int n = 0;
    logic [1:0] p0;
    p0 = pin_drive;
    pwr_off_req = 1'b1; step(1); pwr_off_req = 1'b0;
    chk(ctrl_rst == 1'b1, "R2 reset pulse", ctrl_rst, 1);
    chk(sw_en == 1'b0, "R2 sw_en cleared", sw_en, 0);
    chk(pin_drive == p0, "R2 pins held", pin_drive, p0);
    while (ctrl_rst && n < 500) begin step(1); n++; end
    chk(n >= (RT - 1) * TP && n <= RT * TP + 2, "R2 pulse length", n, RT * TP);
    chk(pin_drive == 2'b00, "R2 lines low", pin_drive, 0);
  endtask

  task automatic t_priority();
    int n = 0;
    pwr_off_req = 1'b1; pwr_on_req = 1'b1; vsw_start_req = 1'b1;
    step(1);
    pwr_off_req = 1'b0; pwr_on_req = 1'b0; vsw_start_req = 1'b0;
    chk(ctrl_rst == 1'b1, "R11 off wins", ctrl_rst, 1);
    chk(pin_drive != 2'b01, "R11 on lost", pin_drive, 0);
    chk(sw_en == 1'b0, "R11 start lost", sw_en, 0);
    while (ctrl_rst && n < 500) begin step(1); n++; end
  endtask

  task automatic t_vsw_ok();
    vsw_done = 1'b1; step(1); vsw_done = 1'b0;
    clk_stop = 1'b1; step(1); clk_stop = 1'b0;
    step(2);
    chk(done_flag == 1'b1, "R12 done sticky", done_flag, 1);
    chk(ckstop_flag == 1'b1, "R12 ckstop sticky", ckstop_flag, 1);
    vsw_start_req = 1'b1; step(1); vsw_start_req = 1'b0;
    chk(sw_en == 1'b1, "R5 sw_en", sw_en, 1);
    chk(done_flag == 1'b0, "R5 done cleared", done_flag, 0);
    vsw_go_req = 1'b1; step(1); vsw_go_req = 1'b0;
    chk(sw_act == 1'b1, "R6 sw_act set", sw_act, 1);
    step(2);
    pwr_off_req = 1'b1; step(1); pwr_off_req = 1'b0;
    step(1);
    chk(ctrl_rst == 1'b0, "R10 off ignored", ctrl_rst, 0);
    chk(pin_drive == 2'b10, "R10 pins kept", pin_drive, 2);
    chk(sw_act == 1'b1, "R10 still waiting", sw_act, 1);
    vsw_done = 1'b1; step(1); vsw_done = 1'b0;
    step(1);
    chk({sw_en, sw_act} == 2'b00, "R7 bits cleared", {sw_en, sw_act}, 0);
    chk({done_flag, ckstop_flag} == 2'b00, "R7 flags cleared",
        {done_flag, ckstop_flag}, 0);
    chk(err_flag == 1'b0, "R7 no error", err_flag, 0);
  endtask

  task automatic t_vsw_ignore();
    vsw_go_req = 1'b1; step(1); vsw_go_req = 1'b0;
    chk(sw_act == 1'b0, "R6 go ignored", sw_act, 0);
    step(3);
    chk(sw_act == 1'b0, "R6 still idle", sw_act, 0);
  endtask

  task automatic t_vsw_timeout();
    int n = 0;
    vsw_start_req = 1'b1; step(1); vsw_start_req = 1'b0;
    vsw_go_req = 1'b1; step(1); vsw_go_req = 1'b0;
    chk(sw_act == 1'b1, "R8 waiting", sw_act, 1);
    while (sw_act && n < 1000) begin step(1); n++; end
    chk(n >= (TT - 1) * TP && n <= TT * TP + 2, "R8 timeout length", n, TT * TP);
    chk(err_flag == 1'b1, "R8 error set", err_flag, 1);
    chk(sw_en == 1'b0, "R8 sw_en cleared", sw_en, 0);
    step(6);
    chk(err_flag == 1'b1, "R9 error holds", err_flag, 1);
    err_clr = 1'b1; step(1); err_clr = 1'b0;
    chk(err_flag == 1'b0, "R9 error cleared", err_flag, 0);
  endtask

  initial begin
    step(5);
    rst = 1'b0;
    step(1);
    t_reset();
    t_power_on();
    t_preserve();
    t_power_off();
    t_priority();
    t_power_on();
    t_vsw_ok();
    t_vsw_ignore();
    t_vsw_timeout();
    step(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(50000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule